// File: doc/BRIEF.md
# Sample Batch Writer

This block takes a set of signed angular-rate samples, one per axis, each time a valid strobe is high. It writes each set into a byte-organised dual-port RAM through that RAM's write port. Every set takes one write cycle. The write carries a byte address, a byte-enable mask and the set packed as little-endian halfwords. The RAM's other port belongs to a processor, and this block never touches it.

The block counts the sets it writes. When a fixed batch is complete, it raises a level interrupt toward the processor's interrupt controller and holds it for a parameterised number of cycles, so the controller is sure to catch it. On the same write the address returns to the start of the buffer, so the next batch overwrites the region the processor has been told to read. Sets that arrive while the interrupt is high are written normally and count toward the next batch.

The defaults are 16-bit samples, three axes, 32 sets per batch and an 8-cycle interrupt hold.

Top module: `sample_batch_writer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `wr_en`, `irq` and `wr_be` are all zero. The first write after reset goes to byte address 0.
- R2: `wr_en` is high in a cycle exactly when `smp_valid` was high at the preceding rising clock edge. No write happens without a valid strobe.
- R3: Axis `a` occupies bits `[16a+15:16a]` of `smp_data`, so X is axis 0, Y is axis 1 and Z is axis 2. Its low byte is stored at byte `addr+2a` and its high byte at `addr+2a+1`. This is little-endian, with X first.
- R4: During a write, `wr_be` has all six bits set, so every byte lane is enabled. When there is no write, `wr_be` is zero.
- R5: Each write advances the byte address by 6, the byte count of one set. Addresses therefore run 0, 6, 12 and so on up to 186.
- R6: `irq` rises in the same cycle that the 32nd write of a batch (address 186) is on the port, and at no other time.
- R7: Once risen, `irq` stays high for exactly `IRQ_HOLD` cycles (default 8) and then falls. The parameter must be at least 4.
- R8: After the 32nd write of a batch, the next write goes to address 0 and a new batch of 32 begins.
- R9: A valid strobe that arrives while `irq` is high is still written, at the next address, and is not dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A new sample set is present on `smp_data` |
| smp_data | input | NUM_AXES*SAMPLE_W (48) | Signed samples, axis 0 in the low bits |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | ADDR_W (8) | RAM byte address of the first byte of the set |
| wr_be | output | NUM_AXES*SAMPLE_W/8 (6) | Byte-lane write enables |
| wr_data | output | NUM_AXES*SAMPLE_W (48) | Packed little-endian set |
| irq | output | 1 | Level interrupt request to the processor |

## Verification
The checker tests the following on every cycle:
- writes follow the valid strobe one cycle later;
- byte enables agree with the write strobe;
- every address is a multiple of 6 inside the buffer;
- the interrupt rises only on the last-slot write and holds for at least four cycles;
- the write after the last slot lands at address 0.

Three properties can only be shown by the bench scenarios, because they depend on whole sequences of sets:
- the exact byte contents in the modelled RAM, and their little-endian order;
- the exact interrupt width of `IRQ_HOLD` cycles;
- that sets arriving during the interrupt, with gaps of zero to three idle cycles, land intact.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

   // Bytes needed to hold a field of the given bit width
   function automatic int bytes_of(input int bits);
      return (bits + 7) / 8;
   endfunction

   // Address bits needed to cover a byte span
   function automatic int span_bits(input int span);
      return (span <= 2) ? 1 : $clog2(span);
   endfunction

endpackage

// File: rtl/sbw_lane_pack.sv
module sbw_lane_pack #(
   parameter int SAMPLE_W = 16,
   parameter int NUM_AXES = 3,
   localparam int SMP_BYTES = sbw_pkg::bytes_of(SAMPLE_W),
   localparam int SET_BYTES = NUM_AXES * SMP_BYTES
) (
   input  logic [NUM_AXES*SAMPLE_W-1:0] smp_in,
   output logic [SET_BYTES*8-1:0]       lanes_out
);

   // Lane (axis*SMP_BYTES + b) carries byte b of the axis: least significant byte first
   for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
      for (genvar b = 0; b < SMP_BYTES; b++) begin : g_byte
         assign lanes_out[(a*SMP_BYTES + b)*8 +: 8] = smp_in[a*SAMPLE_W + b*8 +: 8];
      end
   end

endmodule

// File: rtl/sbw_addr_seq.sv
module sbw_addr_seq #(
   parameter int BATCH  = 32,
   parameter int STEP   = 6,
   parameter int ADDR_W = 8,
   localparam int CNT_W = sbw_pkg::span_bits(BATCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              at_last
);

   logic [CNT_W-1:0]  slot_q;
   logic [ADDR_W-1:0] addr_q;

   assign cur_addr = addr_q;
   assign at_last  = (slot_q == CNT_W'(BATCH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         addr_q <= '0;
      end else if (advance) begin
         if (at_last) begin
            slot_q <= '0;
            addr_q <= '0;
         end else begin
            slot_q <= slot_q + CNT_W'(1);
            addr_q <= addr_q + ADDR_W'(STEP);
         end
      end
   end

endmodule

// File: rtl/sbw_irq_hold.sv
module sbw_irq_hold #(
   parameter int HOLD = 8,
   localparam int TW  = sbw_pkg::span_bits(HOLD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic irq
);

   logic [TW-1:0] left_q;

   // A fresh batch end reloads the full width even if a pulse is already running
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (fire)           left_q <= TW'(HOLD);
      else if (left_q != '0)   left_q <= left_q - TW'(1);
   end

   assign irq = (left_q != '0);

endmodule

// File: rtl/sample_batch_writer.sv
module sample_batch_writer #(
   parameter int SAMPLE_W = 16,
   parameter int NUM_AXES = 3,
   parameter int BATCH    = 32,
   parameter int IRQ_HOLD = 8,
   localparam int SET_BYTES = NUM_AXES * sbw_pkg::bytes_of(SAMPLE_W),
   localparam int ADDR_W    = sbw_pkg::span_bits(BATCH * SET_BYTES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          smp_valid,
   input  logic [NUM_AXES*SAMPLE_W-1:0]  smp_data,
   output logic                          wr_en,
   output logic [ADDR_W-1:0]             wr_addr,
   output logic [SET_BYTES-1:0]          wr_be,
   output logic [SET_BYTES*8-1:0]        wr_data,
   output logic                          irq
);

   if (SAMPLE_W % 8 != 0) begin : g_bad_width
      $error("SAMPLE_W must be a whole number of bytes");
   end
   if (IRQ_HOLD < 4) begin : g_bad_hold
      $error("IRQ_HOLD must be at least 4 cycles");
   end
   if (BATCH < 2) begin : g_bad_batch
      $error("BATCH must be at least 2");
   end

   logic [SET_BYTES*8-1:0] packed_set;
   logic [ADDR_W-1:0]      slot_addr;
   logic                   slot_last;
   logic                   batch_done;

   sbw_lane_pack #(
      .SAMPLE_W (SAMPLE_W),
      .NUM_AXES (NUM_AXES)
   ) u_pack (
      .smp_in    (smp_data),
      .lanes_out (packed_set)
   );

   sbw_addr_seq #(
      .BATCH  (BATCH),
      .STEP   (SET_BYTES),
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (smp_valid),
      .cur_addr (slot_addr),
      .at_last  (slot_last)
   );

   assign batch_done = smp_valid && slot_last;

   sbw_irq_hold #(
      .HOLD (IRQ_HOLD)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (batch_done),
      .irq   (irq)
   );

   // One registered write per accepted set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_be   <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= smp_valid;
         wr_be <= smp_valid ? {SET_BYTES{1'b1}} : '0;
         if (smp_valid) begin
            wr_addr <= slot_addr;
            wr_data <= packed_set;
         end
      end
   end

endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
   parameter int SET_BYTES = 6,
   parameter int BATCH     = 32,
   parameter int ADDR_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_valid,
   input logic                 wr_en,
   input logic [ADDR_W-1:0]    wr_addr,
   input logic [SET_BYTES-1:0] wr_be,
   input logic                 irq
);

   localparam int LAST_ADDR = (BATCH - 1) * SET_BYTES;

   logic prev_was_last;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prev_was_last <= 1'b0;
      else if (wr_en) prev_was_last <= (int'(wr_addr) == LAST_ADDR);
   end

   AST_WR_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> wr_en); // R2
   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !wr_en); // R2
   AST_BE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_be == {SET_BYTES{1'b1}})); // R4
   AST_BE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (wr_be == '0)); // R4
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((int'(wr_addr) % SET_BYTES) == 0 && int'(wr_addr) <= LAST_ADDR)); // R5
   AST_IRQ_ONLY_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (wr_en && int'(wr_addr) == LAST_ADDR)); // R6
   AST_LAST_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) == LAST_ADDR) |-> irq); // R6
   AST_IRQ_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |=> irq ##1 irq ##1 irq); // R7
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && prev_was_last) |-> (wr_addr == '0)); // R8

endmodule

bind sample_batch_writer sbw_checker #(
   .SET_BYTES (SET_BYTES),
   .BATCH     (BATCH),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_be     (wr_be),
   .irq       (irq)
);

// File: tb/tb_sample_batch_writer.sv
module tb_sample_batch_writer;

   localparam int SW = 16;
   localparam int NA = 3;
   localparam int NB = 32;
   localparam int HOLD = 8;
   localparam int EB = 6;
   localparam int AW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic [NA*SW-1:0] smp_data = '0;
   logic wr_en;
   logic [AW-1:0] wr_addr;
   logic [EB-1:0] wr_be;
   logic [EB*8-1:0] wr_data;
   logic irq;

   always #2 clk = ~clk;

   sample_batch_writer #(.SAMPLE_W(SW), .NUM_AXES(NA), .BATCH(NB), .IRQ_HOLD(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .irq(irq));

   int checks = 0;
   int fails = 0;
   logic [7:0] ram [0:255];
   logic [7:0] exp_ram [0:255];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Monitor model
   bit mon_on = 0;
   logic samp_v = 1'b0;
   int exp_addr = 0;
   int wcount = 0;
   int exp_timer = 0;
   int batches = 0;
   int irq_writes = 0;
   bit first_write = 1;

   always @(posedge clk) samp_v <= smp_valid;

   always @(negedge clk) if (mon_on) begin
      check(wr_en == samp_v, "R2", "write strobe vs valid", wr_en, samp_v);
      if (wr_en) begin
         check(int'(wr_addr) == exp_addr,
               first_write ? "R1" : ((wcount == 0) ? "R8" : "R5"),
               "write address", wr_addr, exp_addr);
         check(wr_be == 6'h3f, "R4", "byte enables on write", wr_be, 6'h3f);
         if (exp_timer > 0) begin
            irq_writes++;
            check(1'b1, "R9", "write during irq accepted", 1, 1);
         end
         for (int k = 0; k < EB; k++) ram[(int'(wr_addr) + k) % 256] = wr_data[8*k +: 8];
         first_write = 0;
         wcount++;
         if (wcount == NB) begin
            wcount = 0; exp_addr = 0; exp_timer = HOLD; batches++;
         end else exp_addr += EB;
      end else begin
         check(wr_be == '0, "R4", "byte enables idle", wr_be, 0);
      end
      check(irq == (exp_timer > 0), (exp_timer == HOLD) ? "R6" : "R7",
            "irq level", irq, (exp_timer > 0));
      if (exp_timer > 0) exp_timer--;
   end

   function automatic logic [15:0] axis_val(input int evt, input int a);
      if (evt == 0) return (a == 0) ? 16'h8000 : ((a == 1) ? 16'h7fff : 16'hffff);
      return 16'(evt * 16'h1357 + a * 16'h2b1d + 16'h0101);
   endfunction

   int evt = 0;

   task automatic send(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         smp_valid = 1'b1;
         for (int a = 0; a < NA; a++) begin
            smp_data[a*SW +: SW] = axis_val(evt, a);
            exp_ram[(evt % NB)*EB + 2*a]     = axis_val(evt, a)[7:0];
            exp_ram[(evt % NB)*EB + 2*a + 1] = axis_val(evt, a)[15:8];
         end
         evt++;
         for (int g = 0; g < gap; g++) begin
            @(posedge clk); #1;
            smp_valid = 1'b0;
         end
      end
      @(posedge clk); #1;
      smp_valid = 1'b0;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; exp_ram[i] = 8'h00; end
      repeat (2) @(negedge clk);
      check(wr_en == 1'b0 && irq == 1'b0 && wr_be == '0, "R1", "outputs in reset",
            {wr_en, irq, wr_be}, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(wr_en == 1'b0 && irq == 1'b0 && wr_be == '0, "R1", "outputs after reset",
            {wr_en, irq, wr_be}, 0);
      mon_on = 1;
      send(40, 0);   // back-to-back, continues through the interrupt
      send(24, 1);
      send(24, 2);
      send(40, 3);   // 128 sets in all: four full batches
      repeat (20) @(posedge clk);
      #1;
      check(batches == 4, "R6", "completed batches", batches, 4);
      check(irq_writes > 0, "R9", "sets written during irq", irq_writes, 1);
      check(irq == 1'b0, "R7", "irq low after hold", irq, 0);
      for (int i = 0; i < NB*EB; i++)
         check(ram[i] == exp_ram[i], "R3", "ram byte contents", ram[i], exp_ram[i]);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule